// File: doc/BRIEF.md
# Cross-Lane Swizzle Permutation Unit

This unit rearranges one vector operand across the lanes of a 64-lane wavefront. Each lane carries a 32-bit value. A 16-bit pattern word names, for every destination lane, the source lane whose value it takes. The pattern is formed from two 8-bit immediate fields: the upper field supplies bits 15:8 and the lower field supplies bits 7:0. An execution mask decides which destination lanes are written. Lanes that are switched off pass through the prior contents of the destination register unchanged.

The pattern has two encodings, and bit 15 selects between them. In quad mode the lanes form groups of four, and each lane position in a group picks any member of its own group. In mask mode the low five bits of each lane's own index pass through an AND, then an OR, then an XOR with three 5-bit masks. Bit 5 of the index is left unchanged, so no lane reads from the other 32-lane half. A request is accepted through a valid/ready handshake. Its result appears in an output register one cycle later, and the register holds it until the consumer takes it.

Top module: `swz_unit`

## Requirements
- R1: After reset, out_valid is 0, out_data is all zeros and in_ready is 1.
- R2: Pattern bit 15 chooses the encoding. The value 1 selects quad mode and 0 selects mask mode.
- R3: In quad mode, destination lane L (position p = L mod 4) reads source lane 4*floor(L/4) + pattern[2p+1:2p]. The source never leaves the destination's group of four.
- R4: In quad mode, pattern bits 14:8 have no effect on the result.
- R5: In mask mode, with A = pattern[4:0], O = pattern[9:5] and X = pattern[14:10], lane L reads the lane whose bit 5 equals bit 5 of L and whose bits 4:0 equal ((L[4:0] & A) | O) ^ X.
- R6: A lane whose in_exec bit is 0 outputs its in_prev value. An active lane takes its source value even when the source lane's in_exec bit is 0.
- R7: out_valid goes high on the first clock edge after an accepted request (in_valid and in_ready both 1), and out_data carries that request's result. It drops on the next edge if out_ready is 1 and no new request is accepted.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_data and out_valid stay unchanged.
- R9: The all-zero mask-mode pattern 0x0000 makes every active lane read lane 0 of its own 32-lane half (lane 0 or lane 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request this cycle |
| in_pattern | input | 16 | Swizzle pattern word |
| in_exec | input | LANES (64) | Per-lane execution mask, bit L for lane L |
| in_src | input | LANES*DW (2048) | Source vector, lane L in bits [L*DW +: DW] |
| in_prev | input | LANES*DW (2048) | Prior destination contents, same layout |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | LANES*DW (2048) | Permuted vector, same layout |

## Verification
The identity quad pattern 0xE4 separates correct quad routing from any lane reordering. Quad patterns that differ only in bits 14:8 show whether those bits leak into the selection. The mask-mode patterns 0x0000 and an XOR-by-one swap show whether the field positions and the AND-OR-XOR order are right and whether the 32-lane halves stay apart. Sparse and all-zero execution masks, including one where every active lane reads an inactive source, separate the write gating from the source read. Random patterns in both modes cover the rest of the selection space. A stall with a second request waiting shows whether the held result is overwritten.

// File: rtl/swz_pkg.sv
package swz_pkg;

  localparam int unsigned PAT_W  = 16;
  localparam int unsigned MASK_W = 5;

  // In-group source position for a lane at position pos within its quad.
  function automatic logic [1:0] swz_quad_pick(input logic [1:0] pos,
                                               input logic [7:0] sel);
    logic [1:0] r;
    r = 2'b00;
    for (int k = 0; k < 4; k++) begin
      if (pos == 2'(k)) r = sel[2*k +: 2];
    end
    return r;
  endfunction

  // Low index bits after the AND, OR, XOR masks of the pattern.
  function automatic logic [MASK_W-1:0] swz_mask_pick(input logic [MASK_W-1:0] low,
                                                      input logic [14:0]       fields);
    logic [MASK_W-1:0] and_m, or_m, xor_m;
    and_m = fields[4:0];
    or_m  = fields[9:5];
    xor_m = fields[14:10];
    return ((low & and_m) | or_m) ^ xor_m;
  endfunction

endpackage

// File: rtl/swz_route.sv
module swz_route
  import swz_pkg::*;
#(
  parameter int unsigned LANES = 64,
  localparam int unsigned IW   = $clog2(LANES)
) (
  input  logic [PAT_W-1:0]    pattern,
  output logic [LANES*IW-1:0] src_idx
);

  logic quad_mode;
  assign quad_mode = pattern[PAT_W-1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [IW-1:0] LID = IW'(g);
    logic [IW-1:0] quad_idx;
    logic [IW-1:0] mask_idx;
    assign quad_idx = {LID[IW-1:2], swz_quad_pick(LID[1:0], pattern[7:0])};
    assign mask_idx = {LID[IW-1:MASK_W], swz_mask_pick(LID[MASK_W-1:0], pattern[14:0])};
    assign src_idx[g*IW +: IW] = quad_mode ? quad_idx : mask_idx;
  end

endmodule

// File: rtl/swz_gather.sv
module swz_gather #(
  parameter int unsigned LANES = 64,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(LANES),
  localparam int unsigned VW   = LANES * DW
) (
  input  logic [VW-1:0]       src,
  input  logic [VW-1:0]       prev,
  input  logic [LANES-1:0]    exec,
  input  logic [LANES*IW-1:0] src_idx,
  output logic [VW-1:0]       merged
);

  logic [DW-1:0] src_arr [LANES];

  always_comb begin
    for (int l = 0; l < LANES; l++) src_arr[l] = src[l*DW +: DW];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IW-1:0] idx;
    logic [DW-1:0] picked;
    assign idx    = src_idx[g*IW +: IW];
    assign picked = src_arr[idx];
    assign merged[g*DW +: DW] = exec[g] ? picked : prev[g*DW +: DW];
  end

endmodule

// File: rtl/swz_unit.sv
module swz_unit
  import swz_pkg::*;
#(
  parameter int unsigned LANES = 64,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(LANES),
  localparam int unsigned VW   = LANES * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAT_W-1:0] in_pattern,
  input  logic [LANES-1:0] in_exec,
  input  logic [VW-1:0]    in_src,
  input  logic [VW-1:0]    in_prev,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VW-1:0]    out_data
);

  logic                accept;
  logic                quad_mode_w;
  logic [LANES*IW-1:0] src_idx;
  logic [VW-1:0]       merged;

  assign quad_mode_w = in_pattern[PAT_W-1];
  assign in_ready    = ~out_valid | out_ready;
  assign accept      = in_valid & in_ready;

  swz_route #(.LANES(LANES)) u_route (
    .pattern (in_pattern),
    .src_idx (src_idx)
  );

  swz_gather #(.LANES(LANES), .DW(DW)) u_gather (
    .src     (in_src),
    .prev    (in_prev),
    .exec    (in_exec),
    .src_idx (src_idx),
    .merged  (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= merged;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/swz_unit_chk.sv
module swz_unit_chk #(
  parameter int unsigned LANES = 64,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(LANES),
  localparam int unsigned VW   = LANES * DW
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                accept,
  input logic                quad_mode_w,
  input logic [LANES-1:0]    in_exec,
  input logic [VW-1:0]       in_prev,
  input logic [LANES*IW-1:0] src_idx,
  input logic                out_valid,
  input logic                out_ready,
  input logic [VW-1:0]       out_data
);

  logic          quad_escape;
  logic          half_escape;
  logic [VW-1:0] inact_bits;

  always_comb begin
    quad_escape = 1'b0;
    half_escape = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (src_idx[l*IW+2 +: IW-2] != IW'(l) >> 2) quad_escape = 1'b1;
      if (src_idx[l*IW+IW-1] != 1'((l >> (IW-1)) & 1)) half_escape = 1'b1;
      inact_bits[l*DW +: DW] = {DW{~in_exec[l]}};
    end
  end

  AST_QUAD_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && quad_mode_w) |-> !quad_escape);  // R3

  AST_MASK_IN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !quad_mode_w) |-> !half_escape);  // R5

  AST_INACTIVE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (((out_data ^ $past(in_prev)) & $past(inact_bits)) == '0));  // R6

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);  // R7

  AST_RISE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(accept));  // R7

  AST_STALL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);  // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R8

endmodule

bind swz_unit swz_unit_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .accept      (accept),
  .quad_mode_w (quad_mode_w),
  .in_exec     (in_exec),
  .in_prev     (in_prev),
  .src_idx     (src_idx),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data)
);

// File: tb/swz_unit_test.sv
`timescale 1ns/1ps
module swz_unit_test;

  localparam int LANES = 64;
  localparam int DW    = 32;
  localparam int VW    = LANES * DW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [15:0]      in_pattern = '0;
  logic [LANES-1:0] in_exec = '0;
  logic [VW-1:0]    in_src = '0;
  logic [VW-1:0]    in_prev = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [VW-1:0]    out_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  swz_unit #(.LANES(LANES), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pattern(in_pattern), .in_exec(in_exec), .in_src(in_src), .in_prev(in_prev),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // Source lane for destination lane, written from R3 and R5 arithmetic.
  function automatic int ref_src(input int lane, input logic [15:0] pat);
    int p, lo, a, o, x;
    if (pat[15]) begin
      p = lane % 4;
      return (lane - p) + ((int'(pat) >> (2 * p)) % 4);
    end
    a  = int'(pat) % 32;
    o  = (int'(pat) / 32) % 32;
    x  = (int'(pat) / 1024) % 32;
    lo = ((lane % 32) & a | o) ^ x;
    return (lane / 32) * 32 + lo;
  endfunction

  function automatic logic [VW-1:0] ref_vec(input logic [15:0] pat, input logic [LANES-1:0] ex,
                                            input logic [VW-1:0] s, input logic [VW-1:0] pv);
    logic [VW-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      if (ex[l]) r[l*DW +: DW] = s[ref_src(l, pat)*DW +: DW];
      else       r[l*DW +: DW] = pv[l*DW +: DW];
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*DW +: DW] = $urandom;
    return r;
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      for (int l = 0; l < LANES; l++) begin
        if (act[l*DW +: DW] !== exp[l*DW +: DW]) begin
          $display("FAIL %s: lane %0d actual %h expected %h", req, l,
                   act[l*DW +: DW], exp[l*DW +: DW]);
          break;
        end
      end
    end
  endtask

  // Called just after a falling edge; returns after the next falling edge.
  task automatic run_op(input string req, input logic [15:0] pat, input logic [LANES-1:0] ex,
                        output logic [VW-1:0] got);
    in_pattern = pat;
    in_exec    = ex;
    in_valid   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({req, " out_valid"}, out_valid, 1'b1);
    check_vec(req, out_data, ref_vec(pat, ex, in_src, in_prev));
    got = out_data;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [VW-1:0] got, keep_a;
    logic [VW-1:0] exp_b;
    void'($urandom(32'd4242));
    in_src  = rand_vec();
    in_prev = rand_vec();
    repeat (3) @(negedge clk);
    // R1: reset state
    check_bit("R1 out_valid", out_valid, 1'b0);
    check_bit("R1 in_ready", in_ready, 1'b1);
    check_vec("R1 out_data", out_data, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2, R3: identity quad pattern returns the source
    run_op("R3 identity", 16'h80E4, '1, got);
    check_vec("R2 identity equals src", got, in_src);

    // R4: junk in bits 14:8 of a quad pattern
    run_op("R4 reverse clean", 16'h801B, '1, keep_a);
    run_op("R4 reverse junk", 16'hFF1B, '1, got);
    check_vec("R4 junk ignored", got, keep_a);

    // R9: all-zero mask pattern
    run_op("R9 zero mask", 16'h0000, '1, got);
    for (int l = 0; l < LANES; l++)
      exp_b[l*DW +: DW] = in_src[(l / 32) * 32 * DW +: DW];
    check_vec("R9 half lane 0", got, exp_b);

    // R5: XOR swap of neighbours (and=1F or=0 xor=1)
    run_op("R5 xor swap", 16'h041F, '1, got);
    for (int l = 0; l < LANES; l++) exp_b[l*DW +: DW] = in_src[(l ^ 1) * DW +: DW];
    check_vec("R5 xor swap lanes", got, exp_b);

    // R2: same low bits, different mode bit
    run_op("R2 mask mode 0x00E4", 16'h00E4, '1, got);

    // R6: no active lanes
    run_op("R6 exec zero", 16'h801B, '0, got);
    check_vec("R6 all prev", got, in_prev);

    // R6: active even lanes read inactive odd lane 1 of each quad
    run_op("R6 read inactive src", 16'h8055, {32{2'b01}}, got);

    // R7: valid drops with no new request
    @(negedge clk);
    check_bit("R7 valid drops", out_valid, 1'b0);

    // R8: stall with a second request waiting
    out_ready = 1'b0;
    run_op("R8 first", 16'h0C3E, '1, keep_a);
    in_src     = rand_vec();
    in_pattern = 16'h80B1;
    in_exec    = '1;
    in_valid   = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_bit("R8 in_ready low", in_ready, 1'b0);
      check_bit("R8 valid held", out_valid, 1'b1);
      check_vec("R8 data held", out_data, keep_a);
    end
    exp_b = ref_vec(16'h80B1, '1, in_src, in_prev);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R7 second valid", out_valid, 1'b1);
    check_vec("R7 second data", out_data, exp_b);
    @(negedge clk);

    // R3, R5: random patterns in both modes
    for (int i = 0; i < 60; i++) begin
      logic [15:0] pat;
      pat     = 16'($urandom);
      pat[15] = i[0];
      in_src  = rand_vec();
      in_prev = rand_vec();
      run_op(pat[15] ? "R3 random quad" : "R5 random mask", pat,
             {$urandom, $urandom}, got);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule